// File: doc/BRIEF.md
# Debug-aware low-power clock controller

This block decides which clocks run while the core sits in a low-power mode. The core asks for one of three modes: sleep, stop or standby. A wakeup event brings it back to run. For each mode the controller drives an enable for the free-running core clock (FCLK) and one for the bus clock (HCLK). It also picks whether the clocks come from the software-configured system clock or from the internal RC oscillator, and it can ask for a system reset.

A three-bit debug configuration word holds one override bit per mode. When a bit is set, a debugger can keep the clocks alive in the mode where they would normally stop. The word is cleared only by power-on reset. It keeps its value through system reset and accepts writes while system reset is asserted, so a debugger can set it up before the core starts running code. A second word holds a sticky flag that records a resume from standby.

The sequencer has five states:

- **RUN**: the normal state.
- **SLEEP, STOP, STANDBY**: one state per low-power mode.
- **RESUME**: a one-cycle reset pulse on the way out of standby.

Its transitions are:

- RUN→SLEEP, RUN→STOP and RUN→STANDBY, taken on the mode request.
- SLEEP→RUN and STOP→RUN, taken on wake.
- STANDBY→RESUME, taken on wake.
- RESUME→RUN, taken unconditionally.
- Any state→RUN, taken on system reset.

Top module: `lpclk_ctrl`

## Requirements
- R1: Power-on reset (`por_n` low, asynchronous) clears the debug word and the standby-resume flag to zero. System reset (`sys_rst_n` low) changes neither of them. A full-word write to the debug word takes effect even while system reset is low.
- R2: Address 0 holds the debug word. Bit 0 is the sleep override, bit 1 the stop override and bit 2 the standby override. A read of address 0 returns the three bits in those positions, and bits 31:3 always read as zero.
- R3: A write whose byte enable is anything other than all ones (4'b1111) changes no register, at either address.
- R4: The mode request is encoded as 2'b00 run, 2'b01 sleep, 2'b10 stop and 2'b11 standby. It is sampled only in RUN. The state and all four outputs change at the clock edge that samples a non-run request. In any other state the request has no effect.
- R5: In SLEEP, FCLK is enabled and HCLK is enabled only if the sleep override is 1. The clock source is left as it was.
- R6: In STOP with the stop override at 0, both enables are 0. With the override at 1, both enables are 1 and the source is the RC oscillator (`clk_src_rc`=1). On wake, the controller returns to RUN with `clk_src_rc`=1 whatever the override was.
- R7: In STANDBY with the standby override at 0, both enables are 0 and `sys_rst_req` is 0. With the override at 1, both enables are 1, the source is RC and `sys_rst_req` is 1.
- R8: Wake in STANDBY enters RESUME for exactly one cycle. In RESUME both enables are 1, the source is RC and `sys_rst_req` is 1. The controller then returns to RUN with `sys_rst_req` 0. Entry into RESUME sets the standby-resume flag.
- R9: The standby-resume flag reads as bit 0 of address 1, and bits 31:1 of address 1 read zero. The flag stays set through system reset. It is cleared only by power-on reset or by a full-word write to address 1 with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R10: Wake in SLEEP or STOP returns the controller to RUN at the next edge. Wake in RUN has no effect.
- R11: A `sysclk_go` pulse in RUN switches the source to the configured system clock (`clk_src_rc`=0). Power-on reset and system reset select RC (`clk_src_rc`=1).
- R12: While system reset is low, the controller is held in RUN with both enables at 1 and `sys_rst_req` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, sampled on clk |
| mode_req | input | 2 | Low-power mode request from the core |
| wake | input | 1 | Wakeup event |
| sysclk_go | input | 1 | Pulse: move from RC to the configured system clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = debug word, 1 = resume status |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| fclk_en | output | 1 | Core free-running clock enable |
| hclk_en | output | 1 | Bus clock enable |
| clk_src_rc | output | 1 | 1 = internal RC oscillator, 0 = configured system clock |
| sys_rst_req | output | 1 | System reset request |

## Verification
The bench builds the block with its default 32-bit data path and four byte lanes. With so few configuration bits, every one of the eight debug-word values can be combined with each of the three low-power modes, entered and left. Every one of the fifteen partial byte-enable patterns can also be applied. The bench computes each expected enable, source and reset value from the mode and the override bit. It also reaches the edge cases: writes during system reset, system reset inside a low-power mode, debugger writes while stopped, and the sticky flag across both resets.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_STOP,
        ST_STANDBY,
        ST_RESUME
    } lp_state_e;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_SLEEP   = 2'b01,
        MODE_STOP    = 2'b10,
        MODE_STANDBY = 2'b11
    } lp_mode_e;

    typedef struct packed {
        logic standby_dbg;
        logic stop_dbg;
        logic sleep_dbg;
    } dbg_cfg_t;

    typedef struct packed {
        logic fclk_en;
        logic hclk_en;
        logic src_rc;
        logic rst_req;
    } clk_ctl_t;

    localparam int CFG_W = $bits(dbg_cfg_t);

endpackage

// File: rtl/lpclk_regs.sv
module lpclk_regs
    import lpclk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              resume_set,
    output dbg_cfg_t          cfg_q,
    output dbg_cfg_t          cfg_nxt,
    output logic              resume_flag,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

    logic full_wr;
    logic flag_d;

    assign full_wr = wr && (be == BE_FULL);

    // Debug word: full-word writes only, no system-reset term
    always_comb begin
        cfg_nxt = cfg_q;
        if (full_wr && !addr) begin
            cfg_nxt = dbg_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_nxt;
        end
    end

    // Sticky resume flag: a set from the sequencer beats a clear from software
    always_comb begin
        flag_d = resume_flag;
        if (full_wr && addr && wdata[0]) begin
            flag_d = 1'b0;
        end
        if (resume_set) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            resume_flag <= 1'b0;
        end else begin
            resume_flag <= flag_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata[0] = resume_flag;
        end else begin
            rdata[CFG_W-1:0] = cfg_q;
        end
    end

endmodule

// File: rtl/lpclk_seq.sv
module lpclk_seq
    import lpclk_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst_n,
    input  logic [1:0] mode_req,
    input  logic       wake,
    input  logic       sysclk_go,
    output lp_state_e  state_q,
    output lp_state_e  state_d,
    output logic       src_rc_d,
    output logic       resume_set
);

    logic src_rc_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                unique case (lp_mode_e'(mode_req))
                    MODE_SLEEP:   state_d = ST_SLEEP;
                    MODE_STOP:    state_d = ST_STOP;
                    MODE_STANDBY: state_d = ST_STANDBY;
                    default:      state_d = ST_RUN;
                endcase
            end
            ST_SLEEP,
            ST_STOP: begin
                if (wake) begin
                    state_d = ST_RUN;
                end
            end
            ST_STANDBY: begin
                if (wake) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
        if (!sys_rst_n) begin
            state_d = ST_RUN;
        end
    end

    // Software source selection; stop exit and standby resume revert to RC
    always_comb begin
        src_rc_d = src_rc_q;
        if (state_q == ST_RUN && state_d == ST_RUN && sysclk_go) begin
            src_rc_d = 1'b0;
        end
        if (state_q == ST_STOP && state_d == ST_RUN) begin
            src_rc_d = 1'b1;
        end
        if (state_d == ST_RESUME) begin
            src_rc_d = 1'b1;
        end
        if (!sys_rst_n) begin
            src_rc_d = 1'b1;
        end
    end

    assign resume_set = (state_q == ST_STANDBY) && (state_d == ST_RESUME);

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q  <= ST_RUN;
            src_rc_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            src_rc_q <= src_rc_d;
        end
    end

endmodule

// File: rtl/lpclk_gate.sv
module lpclk_gate
    import lpclk_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  lp_state_e state_d,
    input  dbg_cfg_t  cfg_nxt,
    input  logic      src_rc_d,
    output clk_ctl_t  ctl_q
);

    clk_ctl_t ctl_d;

    // Output decode from the next state, so the enables settle on the edge
    always_comb begin
        ctl_d.fclk_en = 1'b1;
        ctl_d.hclk_en = 1'b1;
        ctl_d.src_rc  = src_rc_d;
        ctl_d.rst_req = 1'b0;
        unique case (state_d)
            ST_RUN: begin
            end
            ST_SLEEP: begin
                ctl_d.hclk_en = cfg_nxt.sleep_dbg;
            end
            ST_STOP: begin
                ctl_d.fclk_en = cfg_nxt.stop_dbg;
                ctl_d.hclk_en = cfg_nxt.stop_dbg;
                ctl_d.src_rc  = 1'b1;
            end
            ST_STANDBY: begin
                ctl_d.fclk_en = cfg_nxt.standby_dbg;
                ctl_d.hclk_en = cfg_nxt.standby_dbg;
                ctl_d.src_rc  = 1'b1;
                ctl_d.rst_req = cfg_nxt.standby_dbg;
            end
            ST_RESUME: begin
                ctl_d.src_rc  = 1'b1;
                ctl_d.rst_req = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '{fclk_en: 1'b1, hclk_en: 1'b1, src_rc: 1'b1, rst_req: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
    import lpclk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [1:0]        mode_req,
    input  logic              wake,
    input  logic              sysclk_go,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fclk_en,
    output logic              hclk_en,
    output logic              clk_src_rc,
    output logic              sys_rst_req
);

    lp_state_e seq_state;
    lp_state_e seq_state_d;
    dbg_cfg_t  cfg_bits;
    dbg_cfg_t  cfg_nxt;
    logic      resume_flag;
    logic      resume_set;
    logic      src_rc_d;
    clk_ctl_t  ctl;

    lpclk_regs #(
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_regs (
        .clk         (clk),
        .por_n       (por_n),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .be          (reg_be),
        .wdata       (reg_wdata),
        .resume_set  (resume_set),
        .cfg_q       (cfg_bits),
        .cfg_nxt     (cfg_nxt),
        .resume_flag (resume_flag),
        .rdata       (reg_rdata)
    );

    lpclk_seq u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .mode_req   (mode_req),
        .wake       (wake),
        .sysclk_go  (sysclk_go),
        .state_q    (seq_state),
        .state_d    (seq_state_d),
        .src_rc_d   (src_rc_d),
        .resume_set (resume_set)
    );

    lpclk_gate u_gate (
        .clk      (clk),
        .por_n    (por_n),
        .state_d  (seq_state_d),
        .cfg_nxt  (cfg_nxt),
        .src_rc_d (src_rc_d),
        .ctl_q    (ctl)
    );

    assign fclk_en     = ctl.fclk_en;
    assign hclk_en     = ctl.hclk_en;
    assign clk_src_rc  = ctl.src_rc;
    assign sys_rst_req = ctl.rst_req;

endmodule

// File: rtl/lpclk_ctrl_chk.sv
module lpclk_ctrl_chk
    import lpclk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [BE_W-1:0]   reg_be,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              fclk_en,
    input logic              hclk_en,
    input logic              clk_src_rc,
    input logic              sys_rst_req,
    input lp_state_e         seq_state,
    input dbg_cfg_t          cfg_bits,
    input logic              resume_flag
);

    localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!por_n)
        (reg_addr == 1'b0) |-> (reg_rdata[DATA_W-1:CFG_W] == '0));

    a_r1_sysrst_keeps_cfg: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !(reg_wr && reg_be == BE_FULL && !reg_addr)) |=> $stable(cfg_bits));

    a_r3_partial_ignored: assert property (@(posedge clk) disable iff (!por_n)
        (reg_wr && reg_be != BE_FULL) |=> $stable(cfg_bits));

    a_r5_sleep_enables: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == ST_SLEEP) |-> (fclk_en && hclk_en == cfg_bits.sleep_dbg));

    a_r6_stop_exit_rc: assert property (@(posedge clk) disable iff (!por_n)
        ($past(seq_state) == ST_STOP && seq_state == ST_RUN) |-> clk_src_rc);

    a_r7_standby_outputs: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == ST_STANDBY) |->
            (sys_rst_req == cfg_bits.standby_dbg && fclk_en == cfg_bits.standby_dbg));

    a_r8_resume_pulse: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == ST_RESUME) |-> (sys_rst_req && fclk_en && hclk_en && resume_flag));

    a_r8_resume_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == ST_RESUME) |=> (seq_state == ST_RUN));

    a_r12_sysrst_run: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n) |=> (seq_state == ST_RUN && fclk_en && hclk_en && !sys_rst_req));

endmodule

bind lpclk_ctrl lpclk_ctrl_chk #(
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_be      (reg_be),
    .reg_rdata   (reg_rdata),
    .fclk_en     (fclk_en),
    .hclk_en     (hclk_en),
    .clk_src_rc  (clk_src_rc),
    .sys_rst_req (sys_rst_req),
    .seq_state   (seq_state),
    .cfg_bits    (cfg_bits),
    .resume_flag (resume_flag)
);

// File: tb/lpclk_ctrl_bench.sv
`timescale 1ns/1ps
module lpclk_ctrl_bench;

    logic        clk = 1'b0;
    logic        por_n;
    logic        sys_rst_n;
    logic [1:0]  mode_req;
    logic        wake;
    logic        sysclk_go;
    logic        reg_wr;
    logic        reg_addr;
    logic [3:0]  reg_be;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        fclk_en;
    logic        hclk_en;
    logic        clk_src_rc;
    logic        sys_rst_req;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    lpclk_ctrl u_lpclk_ctrl (
        .clk         (clk),
        .por_n       (por_n),
        .sys_rst_n   (sys_rst_n),
        .mode_req    (mode_req),
        .wake        (wake),
        .sysclk_go   (sysclk_go),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_be      (reg_be),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fclk_en     (fclk_en),
        .hclk_en     (hclk_en),
        .clk_src_rc  (clk_src_rc),
        .sys_rst_req (sys_rst_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Outputs packed as {fclk, hclk, src_rc, rst_req}
    task automatic check_out(input string req, input logic [3:0] exp);
        check(req, {28'd0, fclk_en, hclk_en, clk_src_rc, sys_rst_req}, {28'd0, exp});
    endtask

    task automatic write(input logic a, input logic [3:0] be, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_be    = be;
        reg_wdata = d;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic read(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_mode(input logic [1:0] m);
        mode_req = m;
        tick();
        mode_req = 2'b00;
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        tick();
        wake = 1'b0;
    endtask

    task automatic pulse_go();
        sysclk_go = 1'b1;
        tick();
        sysclk_go = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [3:0]  exp;
        logic [3:0]  held;

        por_n = 1'b0; sys_rst_n = 1'b0; mode_req = 2'b00; wake = 1'b0;
        sysclk_go = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_be = 4'h0; reg_wdata = '0;
        repeat (3) tick();

        // R1/R12: reset state
        check_out("R12 reset outputs", 4'b1110);
        read(1'b0, rd); check("R1 cfg after POR", rd, 32'd0);
        read(1'b1, rd); check("R1 flag after POR", rd, 32'd0);

        // R1: write while system reset held
        por_n = 1'b1;
        tick();
        write(1'b0, 4'hF, 32'd5);
        read(1'b0, rd); check("R1 write during system reset", rd, 32'd5);
        sys_rst_n = 1'b1;
        tick();
        sys_rst_n = 1'b0; tick(); tick(); sys_rst_n = 1'b1; tick();
        read(1'b0, rd); check("R1 cfg kept over system reset", rd, 32'd5);

        // R2: all debug word values, reserved bits read zero
        for (int v = 0; v < 8; v++) begin
            write(1'b0, 4'hF, 32'hFFFF_FFF8 | 32'(v));
            read(1'b0, rd); check("R2 readback", rd, 32'(v));
        end

        // R3: every partial byte enable ignored on both addresses
        write(1'b0, 4'hF, 32'd3);
        for (int b = 0; b < 15; b++) begin
            write(1'b0, 4'(b), 32'd4);
            read(1'b0, rd); check("R3 partial write cfg", rd, 32'd3);
        end

        // R10: wake in run ignored
        pulse_wake();
        check_out("R10 wake in run", 4'b1110);

        // R4..R8, R11: every mode against every debug word
        for (int m = 1; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                write(1'b0, 4'hF, 32'(c));
                pulse_go();
                check("R11 system clock selected", {31'd0, clk_src_rc}, 32'd0);
                pulse_mode(2'(m));
                if (m == 1)      exp = {1'b1, c[0], 1'b0, 1'b0};
                else if (m == 2) exp = {c[1], c[1], 1'b1, 1'b0};
                else             exp = {c[2], c[2], 1'b1, c[2]};
                check_out((m == 1) ? "R5 sleep" : (m == 2) ? "R6 stop" : "R7 standby", exp);
                held = exp;
                pulse_mode((m == 1) ? 2'b10 : 2'b01);
                check_out("R4 request ignored outside run", held);
                pulse_wake();
                if (m == 3) begin
                    check_out("R8 resume outputs", 4'b1111);
                    read(1'b1, rd); check("R8 flag set", rd, 32'd1);
                    tick();
                    check_out("R8 back to run", 4'b1110);
                    write(1'b1, 4'hF, 32'd1);
                    read(1'b1, rd); check("R9 flag cleared", rd, 32'd0);
                end else if (m == 2) begin
                    check_out("R6 stop exit reverts to RC", 4'b1110);
                end else begin
                    check_out("R10 sleep exit keeps source", 4'b1100);
                end
            end
        end

        // R9: flag stickiness
        write(1'b0, 4'hF, 32'd0);
        pulse_mode(2'b11);
        pulse_wake();
        tick();
        sys_rst_n = 1'b0; tick(); sys_rst_n = 1'b1; tick();
        read(1'b1, rd); check("R9 flag over system reset", rd, 32'd1);
        write(1'b1, 4'hF, 32'd0);
        read(1'b1, rd); check("R9 write zero keeps flag", rd, 32'd1);
        write(1'b1, 4'h7, 32'd1);
        read(1'b1, rd); check("R3 partial clear ignored", rd, 32'd1);
        write(1'b1, 4'hF, 32'd1);
        read(1'b1, rd); check("R9 explicit clear", rd, 32'd0);

        // R12: system reset inside sleep
        pulse_go();
        pulse_mode(2'b01);
        check_out("R5 sleep no override", 4'b1000);
        sys_rst_n = 1'b0; tick();
        check_out("R12 system reset in sleep", 4'b1110);
        sys_rst_n = 1'b1; tick();
        read(1'b0, rd); check("R1 cfg after reset in sleep", rd, 32'd0);

        // R6: debugger write while stopped turns clocks on
        pulse_mode(2'b10);
        check_out("R6 stop clocks off", 4'b0010);
        write(1'b0, 4'hF, 32'd2);
        check_out("R6 stop override live", 4'b1110);
        pulse_wake();
        check_out("R10 stop wake", 4'b1110);

        // R1: power-on reset clears both words
        pulse_mode(2'b11);
        pulse_wake();
        tick();
        por_n = 1'b0; #1;
        read(1'b0, rd); check("R1 POR clears cfg", rd, 32'd0);
        read(1'b1, rd); check("R1 POR clears flag", rd, 32'd0);
        por_n = 1'b1;
        tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule